// File: doc/BRIEF.md
# I/O Delay Setting Register Bank

This block holds the delay and phase settings that tune a parallel I/O interface. Each data pin has an output phase and an input delay. Each lane has a strobe input delay, a strobe-enable phase, a strobe-enable delay and a read-valid delay. Software reaches these settings through a memory-mapped slave port. For every setting the block drives an effective value to the delay-chain logic downstream. That value is taken either from a build-time default or from the word software wrote. Each kind of setting follows its own selection rule.

The bus address splits into several fields: an interface identifier, a base field, a reserved field, a lane number, a pin number and a register selector. An instance answers only to its own identifier and base. Reads have a fixed latency of one cycle. The slave never applies back-pressure: `avs_waitrequest` stays low, so every read or write is taken in the cycle it is presented. Read data is valid only in the cycle that `avs_readdatavalid` is high.

Top module: `iodly_regbank`

## Requirements
- R1: An access is taken only when address bits [30:27] equal `IF_ID`, bits [26:24] equal `BASE_ID`, bits [23:21] are zero and the lane field [20:13] is below `NUM_LANES`. The per-pin selectors also need the pin field [12:8] below `PINS_PER_LANE`. Any other write changes nothing, and any other read returns zero.
- R2: After reset every stored word reads zero. The effective output phase, strobe-enable phase, strobe-enable delay and read-valid delay equal their defaults, and the effective input delay and strobe input delay are zero.
- R3: The output phase (selector 0x00, per pin) holds a 13-bit value in bits [12:0]. Its effective value is the default until the first write to that pin's register. From then on it is the written value, even if zero, and only reset brings it back to the default.
- R4: The input delay (selector 0x01, per pin) holds a 9-bit value in [8:0] and an enable in bit 12. Its effective value is the stored value when the enable is 1 and zero when it is 0.
- R5: The strobe input delay (selector 0x02, per lane) holds a 10-bit value in [9:0] and an enable in bit 12. Its effective value is the stored value when the enable is 1 and zero otherwise.
- R6: Selectors 0x03 (strobe-enable phase, 13 bits [12:0]), 0x04 (strobe-enable delay, 6 bits [5:0]) and 0x05 (read-valid delay, 7 bits [6:0]) are per lane and each has a select bit in bit 15. With bit 15 at 0 the effective value is the default; with bit 15 at 1 it is the stored value.
- R7: Written bits beyond a field, and reserved bits, are dropped, never saturated. A read returns only the field bits and the enable or select bit, with all other bits zero.
- R8: A read presented in cycle N returns its data with `avs_readdatavalid` high in cycle N+1. `avs_readdatavalid` is low in the cycle after a cycle with no read, and `avs_waitrequest` is always low.
- R9: Every lane keeps its own copy of the lane settings, and every pin keeps its own copy of the pin settings. A write reaches only the addressed lane or pin.
- R10: Selector values 0x06 to 0xFF address no register. Writes to them are ignored and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| avs_address | input | 31 | Bus address (identifier, base, lane, pin, selector) |
| avs_read | input | 1 | Read strobe |
| avs_write | input | 1 | Write strobe |
| avs_writedata | input | 32 | Write data |
| avs_readdata | output | 32 | Read data, valid with avs_readdatavalid |
| avs_readdatavalid | output | 1 | Read data valid, one cycle after the read |
| avs_waitrequest | output | 1 | Always low: no stall |
| out_phase_o | output | NUM_LANES*PINS_PER_LANE*13 | Effective output phase per pin, pin index lane*PINS_PER_LANE+pin |
| in_dly_o | output | NUM_LANES*PINS_PER_LANE*9 | Effective input delay per pin |
| strb_in_dly_o | output | NUM_LANES*10 | Effective strobe input delay per lane |
| se_phase_o | output | NUM_LANES*13 | Effective strobe-enable phase per lane |
| se_dly_o | output | NUM_LANES*6 | Effective strobe-enable delay per lane |
| rd_valid_dly_o | output | NUM_LANES*7 | Effective read-valid delay per lane |

## Verification
The bench builds the block with two lanes of four pins, interface identifier 5 and base 3. A mismatched identifier or base is therefore a real miss, and lane numbers 2 and up fall outside the bank. Every default is a nonzero value that no reset word can produce. This keeps a default-selected output distinct from a forced-zero output and from a sticky written zero. With two lanes, the bench can show that a lane write stays in its own lane. The pin field can reach values 4 to 31, which lie past the last pin.

// File: rtl/iodly_pkg.sv
package iodly_pkg;
  localparam int OPH_W = 13;
  localparam int IDL_W = 9;
  localparam int SID_W = 10;
  localparam int SEP_W = 13;
  localparam int SED_W = 6;
  localparam int RVD_W = 7;

  typedef enum logic [7:0] {
    SEL_OPH = 8'h00,
    SEL_IDL = 8'h01,
    SEL_SID = 8'h02,
    SEL_SEP = 8'h03,
    SEL_SED = 8'h04,
    SEL_RVD = 8'h05
  } reg_sel_e;

  typedef struct packed {
    logic             en;
    logic [IDL_W-1:0] val;
  } idl_t;

  typedef struct packed {
    logic             en;
    logic [SID_W-1:0] val;
  } sid_t;

  typedef struct packed {
    logic             sel;
    logic [SEP_W-1:0] val;
  } sep_t;

  typedef struct packed {
    logic             sel;
    logic [SED_W-1:0] val;
  } sed_t;

  typedef struct packed {
    logic             sel;
    logic [RVD_W-1:0] val;
  } rvd_t;
endpackage

// File: rtl/iodly_addr_dec.sv
module iodly_addr_dec #(
  parameter int         NUM_LANES = 2,
  parameter int         PINS      = 4,
  parameter logic [3:0] IF_ID     = 4'h0,
  parameter logic [2:0] BASE_ID   = 3'h0,
  parameter int         LANE_IW   = 1,
  parameter int         PIN_IW    = 2
) (
  input  logic [30:0]        addr_i,
  output logic               inst_hit_o,
  output logic               lane_ok_o,
  output logic               pin_ok_o,
  output logic [LANE_IW-1:0] lane_o,
  output logic [PIN_IW-1:0]  pin_o,
  output logic [7:0]         sel_o
);
  localparam logic [8:0] LANE_LIM = 9'(NUM_LANES);
  localparam logic [5:0] PIN_LIM  = 6'(PINS);

  assign inst_hit_o = (addr_i[30:27] == IF_ID) && (addr_i[26:24] == BASE_ID)
                      && (addr_i[23:21] == 3'b000);
  assign lane_ok_o  = {1'b0, addr_i[20:13]} < LANE_LIM;
  assign pin_ok_o   = {1'b0, addr_i[12:8]} < PIN_LIM;
  assign lane_o     = addr_i[13 +: LANE_IW];
  assign pin_o      = addr_i[8 +: PIN_IW];
  assign sel_o      = addr_i[7:0];
endmodule

// File: rtl/iodly_pin_regs.sv
module iodly_pin_regs
  import iodly_pkg::*;
#(
  parameter logic [OPH_W-1:0] DFLT_OPH = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_oph_i,
  input  logic             wr_idl_i,
  input  logic [12:0]      wdata_i,
  output logic [31:0]      oph_word_o,
  output logic [31:0]      idl_word_o,
  output logic [OPH_W-1:0] eff_oph_o,
  output logic [IDL_W-1:0] eff_idl_o
);
  logic [OPH_W-1:0] oph_q;
  logic             oph_owned_q;
  idl_t             idl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oph_q       <= '0;
      oph_owned_q <= 1'b0;
      idl_q       <= '0;
    end else begin
      if (wr_oph_i) begin
        oph_q       <= wdata_i[OPH_W-1:0];
        oph_owned_q <= 1'b1;
      end
      if (wr_idl_i) begin
        idl_q.en  <= wdata_i[12];
        idl_q.val <= wdata_i[IDL_W-1:0];
      end
    end
  end

  assign eff_oph_o  = oph_owned_q ? oph_q : DFLT_OPH;
  assign eff_idl_o  = idl_q.en ? idl_q.val : '0;
  assign oph_word_o = 32'(oph_q);
  assign idl_word_o = 32'({idl_q.en, 3'b000, idl_q.val});

  // R3
  oph_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oph_i |=> eff_oph_o == $past(wdata_i[OPH_W-1:0]));
  // R3
  oph_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_oph_i |=> eff_oph_o == $past(eff_oph_o));
  // R4
  idl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idl_i && !wdata_i[12]) |=> eff_idl_o == '0);
endmodule

// File: rtl/iodly_lane_regs.sv
module iodly_lane_regs
  import iodly_pkg::*;
#(
  parameter logic [SEP_W-1:0] DFLT_SEP = '0,
  parameter logic [SED_W-1:0] DFLT_SED = '0,
  parameter logic [RVD_W-1:0] DFLT_RVD = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sid_i,
  input  logic             wr_sep_i,
  input  logic             wr_sed_i,
  input  logic             wr_rvd_i,
  input  logic [15:0]      wdata_i,
  output logic [31:0]      sid_word_o,
  output logic [31:0]      sep_word_o,
  output logic [31:0]      sed_word_o,
  output logic [31:0]      rvd_word_o,
  output logic [SID_W-1:0] eff_sid_o,
  output logic [SEP_W-1:0] eff_sep_o,
  output logic [SED_W-1:0] eff_sed_o,
  output logic [RVD_W-1:0] eff_rvd_o
);
  sid_t sid_q;
  sep_t sep_q;
  sed_t sed_q;
  rvd_t rvd_q;
  logic unused_rsv_bits;

  assign unused_rsv_bits = ^wdata_i[14:13];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sid_q <= '0;
      sep_q <= '0;
      sed_q <= '0;
      rvd_q <= '0;
    end else begin
      if (wr_sid_i) sid_q <= '{en: wdata_i[12], val: wdata_i[SID_W-1:0]};
      if (wr_sep_i) sep_q <= '{sel: wdata_i[15], val: wdata_i[SEP_W-1:0]};
      if (wr_sed_i) sed_q <= '{sel: wdata_i[15], val: wdata_i[SED_W-1:0]};
      if (wr_rvd_i) rvd_q <= '{sel: wdata_i[15], val: wdata_i[RVD_W-1:0]};
    end
  end

  assign eff_sid_o = sid_q.en  ? sid_q.val : '0;
  assign eff_sep_o = sep_q.sel ? sep_q.val : DFLT_SEP;
  assign eff_sed_o = sed_q.sel ? sed_q.val : DFLT_SED;
  assign eff_rvd_o = rvd_q.sel ? rvd_q.val : DFLT_RVD;

  assign sid_word_o = 32'({sid_q.en, 2'b00, sid_q.val});
  assign sep_word_o = 32'({sep_q.sel, 2'b00, sep_q.val});
  assign sed_word_o = 32'({sed_q.sel, 9'b0, sed_q.val});
  assign rvd_word_o = 32'({rvd_q.sel, 8'b0, rvd_q.val});

  // R5
  sid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sid_i && !wdata_i[12]) |=> eff_sid_o == '0);
  // R6
  sep_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sep_i && !wdata_i[15]) |=> eff_sep_o == DFLT_SEP);
  // R6
  sed_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sed_i && wdata_i[15]) |=> eff_sed_o == $past(wdata_i[SED_W-1:0]));
endmodule

// File: rtl/iodly_regbank.sv
module iodly_regbank
  import iodly_pkg::*;
#(
  parameter int               NUM_LANES     = 2,
  parameter int               PINS_PER_LANE = 4,
  parameter logic [3:0]       IF_ID         = 4'h0,
  parameter logic [2:0]       BASE_ID       = 3'h3,
  parameter logic [OPH_W-1:0] DFLT_OPH      = 13'h0400,
  parameter logic [SEP_W-1:0] DFLT_SEP      = 13'h0100,
  parameter logic [SED_W-1:0] DFLT_SED      = 6'd4,
  parameter logic [RVD_W-1:0] DFLT_RVD      = 7'd8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [30:0]                              avs_address,
  input  logic                                     avs_read,
  input  logic                                     avs_write,
  input  logic [31:0]                              avs_writedata,
  output logic [31:0]                              avs_readdata,
  output logic                                     avs_readdatavalid,
  output logic                                     avs_waitrequest,
  output logic [NUM_LANES*PINS_PER_LANE*OPH_W-1:0] out_phase_o,
  output logic [NUM_LANES*PINS_PER_LANE*IDL_W-1:0] in_dly_o,
  output logic [NUM_LANES*SID_W-1:0]               strb_in_dly_o,
  output logic [NUM_LANES*SEP_W-1:0]               se_phase_o,
  output logic [NUM_LANES*SED_W-1:0]               se_dly_o,
  output logic [NUM_LANES*RVD_W-1:0]               rd_valid_dly_o
);
  localparam int NPINS   = NUM_LANES * PINS_PER_LANE;
  localparam int LANE_IW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int PIN_IW  = (PINS_PER_LANE > 1) ? $clog2(PINS_PER_LANE) : 1;

  logic               dec_hit, dec_lane_ok, dec_pin_ok;
  logic [LANE_IW-1:0] dec_lane;
  logic [PIN_IW-1:0]  dec_pin;
  logic [7:0]         dec_sel;
  logic               wr_go;
  logic [31:0]        rd_mux;
  logic               unused_wdata_hi;

  logic [31:0] oph_w [NPINS];
  logic [31:0] idl_w [NPINS];
  logic [31:0] sid_w [NUM_LANES];
  logic [31:0] sep_w [NUM_LANES];
  logic [31:0] sed_w [NUM_LANES];
  logic [31:0] rvd_w [NUM_LANES];

  assign unused_wdata_hi = ^avs_writedata[31:16];
  assign avs_waitrequest = 1'b0;

  iodly_addr_dec #(
    .NUM_LANES(NUM_LANES), .PINS(PINS_PER_LANE), .IF_ID(IF_ID),
    .BASE_ID(BASE_ID), .LANE_IW(LANE_IW), .PIN_IW(PIN_IW)
  ) u_dec (
    .addr_i(avs_address), .inst_hit_o(dec_hit), .lane_ok_o(dec_lane_ok),
    .pin_ok_o(dec_pin_ok), .lane_o(dec_lane), .pin_o(dec_pin), .sel_o(dec_sel)
  );

  assign wr_go = avs_write && dec_hit && dec_lane_ok;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic lane_wr;
    assign lane_wr = wr_go && (dec_lane == LANE_IW'(l));

    iodly_lane_regs #(
      .DFLT_SEP(DFLT_SEP), .DFLT_SED(DFLT_SED), .DFLT_RVD(DFLT_RVD)
    ) u_lane (
      .clk(clk), .rst_n(rst_n),
      .wr_sid_i(lane_wr && dec_sel == SEL_SID),
      .wr_sep_i(lane_wr && dec_sel == SEL_SEP),
      .wr_sed_i(lane_wr && dec_sel == SEL_SED),
      .wr_rvd_i(lane_wr && dec_sel == SEL_RVD),
      .wdata_i(avs_writedata[15:0]),
      .sid_word_o(sid_w[l]), .sep_word_o(sep_w[l]),
      .sed_word_o(sed_w[l]), .rvd_word_o(rvd_w[l]),
      .eff_sid_o(strb_in_dly_o[l*SID_W +: SID_W]),
      .eff_sep_o(se_phase_o[l*SEP_W +: SEP_W]),
      .eff_sed_o(se_dly_o[l*SED_W +: SED_W]),
      .eff_rvd_o(rd_valid_dly_o[l*RVD_W +: RVD_W])
    );

    for (genvar p = 0; p < PINS_PER_LANE; p++) begin : g_pin
      localparam int IDX = l * PINS_PER_LANE + p;
      logic pin_wr;
      assign pin_wr = lane_wr && dec_pin_ok && (dec_pin == PIN_IW'(p));

      iodly_pin_regs #(.DFLT_OPH(DFLT_OPH)) u_pin (
        .clk(clk), .rst_n(rst_n),
        .wr_oph_i(pin_wr && dec_sel == SEL_OPH),
        .wr_idl_i(pin_wr && dec_sel == SEL_IDL),
        .wdata_i(avs_writedata[12:0]),
        .oph_word_o(oph_w[IDX]), .idl_word_o(idl_w[IDX]),
        .eff_oph_o(out_phase_o[IDX*OPH_W +: OPH_W]),
        .eff_idl_o(in_dly_o[IDX*IDL_W +: IDL_W])
      );
    end
  end

  always_comb begin
    rd_mux = '0;
    if (dec_hit && dec_lane_ok) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if (dec_lane == LANE_IW'(l)) begin
          case (dec_sel)
            SEL_SID: rd_mux = sid_w[l];
            SEL_SEP: rd_mux = sep_w[l];
            SEL_SED: rd_mux = sed_w[l];
            SEL_RVD: rd_mux = rvd_w[l];
            SEL_OPH, SEL_IDL: begin
              for (int p = 0; p < PINS_PER_LANE; p++) begin
                if (dec_pin_ok && dec_pin == PIN_IW'(p)) begin
                  rd_mux = (dec_sel == SEL_OPH) ? oph_w[l*PINS_PER_LANE+p]
                                                : idl_w[l*PINS_PER_LANE+p];
                end
              end
            end
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avs_readdatavalid <= 1'b0;
      avs_readdata      <= '0;
    end else begin
      avs_readdatavalid <= avs_read;
      avs_readdata      <= avs_read ? rd_mux : '0;
    end
  end

  // R8
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avs_read |=> avs_readdatavalid);
  // R8
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !avs_read |=> !avs_readdatavalid);
  // R1
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avs_read && !dec_hit) |=> avs_readdata == '0);
endmodule

// File: tb/iodly_regbank_bench.sv
module iodly_regbank_bench;
  import iodly_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 2;
  localparam int NP = 4;
  localparam logic [3:0] T_ID = 4'h5;
  localparam logic [2:0] T_BASE = 3'h3;
  localparam logic [12:0] D_OPH = 13'h0A40;
  localparam logic [12:0] D_SEP = 13'h0123;
  localparam logic [5:0]  D_SED = 6'd17;
  localparam logic [6:0]  D_RVD = 7'd45;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [30:0] avs_address = '0;
  logic avs_read = 1'b0, avs_write = 1'b0;
  logic [31:0] avs_writedata = '0;
  logic [31:0] avs_readdata;
  logic avs_readdatavalid, avs_waitrequest;
  logic [NL*NP*13-1:0] out_phase_o;
  logic [NL*NP*9-1:0]  in_dly_o;
  logic [NL*10-1:0] strb_in_dly_o;
  logic [NL*13-1:0] se_phase_o;
  logic [NL*6-1:0]  se_dly_o;
  logic [NL*7-1:0]  rd_valid_dly_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  iodly_regbank #(
    .NUM_LANES(NL), .PINS_PER_LANE(NP), .IF_ID(T_ID), .BASE_ID(T_BASE),
    .DFLT_OPH(D_OPH), .DFLT_SEP(D_SEP), .DFLT_SED(D_SED), .DFLT_RVD(D_RVD)
  ) u_iodly_regbank (
    .clk(clk), .rst_n(rst_n), .avs_address(avs_address), .avs_read(avs_read),
    .avs_write(avs_write), .avs_writedata(avs_writedata),
    .avs_readdata(avs_readdata), .avs_readdatavalid(avs_readdatavalid),
    .avs_waitrequest(avs_waitrequest), .out_phase_o(out_phase_o),
    .in_dly_o(in_dly_o), .strb_in_dly_o(strb_in_dly_o),
    .se_phase_o(se_phase_o), .se_dly_o(se_dly_o),
    .rd_valid_dly_o(rd_valid_dly_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_oph [NL*NP];
  bit          m_own [NL*NP];
  logic [31:0] m_idl [NL*NP];
  logic [31:0] m_sid [NL];
  logic [31:0] m_sep [NL];
  logic [31:0] m_sed [NL];
  logic [31:0] m_rvd [NL];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [30:0] mk_addr(input logic [3:0] id, input logic [2:0] b,
                                          input int lane, input int pin, input logic [7:0] sel);
    return {id, b, 3'b000, 8'(lane), 5'(pin), sel};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NL*NP; i++) begin
      m_oph[i] = '0; m_own[i] = 1'b0; m_idl[i] = '0;
    end
    for (int l = 0; l < NL; l++) begin
      m_sid[l] = '0; m_sep[l] = '0; m_sed[l] = '0; m_rvd[l] = '0;
    end
  endtask

  function automatic bit a_hit(input logic [30:0] a);
    return a[30:27] == T_ID && a[26:24] == T_BASE && a[23:21] == 3'b000
           && int'(a[20:13]) < NL;
  endfunction

  task automatic model_write(input logic [30:0] a, input logic [31:0] d);
    int lane, pin;
    lane = int'(a[20:13]);
    pin  = int'(a[12:8]);
    if (!a_hit(a)) return;
    case (a[7:0])
      8'h00: if (pin < NP) begin m_oph[lane*NP+pin] = d & 32'h1FFF; m_own[lane*NP+pin] = 1'b1; end
      8'h01: if (pin < NP) m_idl[lane*NP+pin] = d & 32'h11FF;
      8'h02: m_sid[lane] = d & 32'h13FF;
      8'h03: m_sep[lane] = d & 32'h9FFF;
      8'h04: m_sed[lane] = d & 32'h803F;
      8'h05: m_rvd[lane] = d & 32'h807F;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_rd(input logic [30:0] a);
    int lane, pin;
    lane = int'(a[20:13]);
    pin  = int'(a[12:8]);
    if (!a_hit(a)) return '0;
    case (a[7:0])
      8'h00: return (pin < NP) ? m_oph[lane*NP+pin] : '0;
      8'h01: return (pin < NP) ? m_idl[lane*NP+pin] : '0;
      8'h02: return m_sid[lane];
      8'h03: return m_sep[lane];
      8'h04: return m_sed[lane];
      8'h05: return m_rvd[lane];
      default: return '0;
    endcase
  endfunction

  task automatic check_outs(input string req);
    logic [NL*NP*13-1:0] e_oph;
    logic [NL*NP*9-1:0]  e_idl;
    logic [NL*10-1:0] e_sid;
    logic [NL*13-1:0] e_sep;
    logic [NL*6-1:0]  e_sed;
    logic [NL*7-1:0]  e_rvd;
    for (int i = 0; i < NL*NP; i++) begin
      e_oph[i*13 +: 13] = m_own[i] ? m_oph[i][12:0] : D_OPH;
      e_idl[i*9 +: 9]   = m_idl[i][12] ? m_idl[i][8:0] : 9'd0;
    end
    for (int l = 0; l < NL; l++) begin
      e_sid[l*10 +: 10] = m_sid[l][12] ? m_sid[l][9:0] : 10'd0;
      e_sep[l*13 +: 13] = m_sep[l][15] ? m_sep[l][12:0] : D_SEP;
      e_sed[l*6 +: 6]   = m_sed[l][15] ? m_sed[l][5:0] : D_SED;
      e_rvd[l*7 +: 7]   = m_rvd[l][15] ? m_rvd[l][6:0] : D_RVD;
    end
    chk(out_phase_o == e_oph, req, "out_phase_o", 128'(out_phase_o), 128'(e_oph));
    chk(in_dly_o == e_idl, req, "in_dly_o", 128'(in_dly_o), 128'(e_idl));
    chk(strb_in_dly_o == e_sid, req, "strb_in_dly_o", 128'(strb_in_dly_o), 128'(e_sid));
    chk(se_phase_o == e_sep, req, "se_phase_o", 128'(se_phase_o), 128'(e_sep));
    chk(se_dly_o == e_sed, req, "se_dly_o", 128'(se_dly_o), 128'(e_sed));
    chk(rd_valid_dly_o == e_rvd, req, "rd_valid_dly_o", 128'(rd_valid_dly_o), 128'(e_rvd));
  endtask

  task automatic do_write(input logic [30:0] a, input logic [31:0] d);
    @(negedge clk);
    avs_address = a; avs_writedata = d; avs_write = 1'b1;
    @(negedge clk);
    avs_write = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [30:0] a, input string req);
    logic [31:0] e;
    e = exp_rd(a);
    @(negedge clk);
    avs_address = a; avs_read = 1'b1;
    @(negedge clk);
    avs_read = 1'b0;
    // R8: data valid one cycle after the read
    chk(avs_readdatavalid === 1'b1, "R8", "readdatavalid", 128'(avs_readdatavalid), 128'(1));
    chk(avs_readdata === e, req, "readdata", 128'(avs_readdata), 128'(e));
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    apply_reset();

    // R2: reset values
    check_outs("R2");
    for (int s = 0; s < 6; s++) do_read(mk_addr(T_ID, T_BASE, 1, 2, 8'(s)), "R2");
    chk(avs_waitrequest === 1'b0, "R8", "waitrequest", 128'(avs_waitrequest), 128'(0));

    // R3: default until first write, then sticky written value (even zero)
    do_read(mk_addr(T_ID, T_BASE, 0, 1, 8'h00), "R3");
    do_write(mk_addr(T_ID, T_BASE, 0, 1, 8'h00), 32'hFFFF_1ABC);
    check_outs("R3");
    do_read(mk_addr(T_ID, T_BASE, 0, 1, 8'h00), "R7");
    do_write(mk_addr(T_ID, T_BASE, 0, 1, 8'h00), 32'h0000_0000);
    chk(out_phase_o[1*13 +: 13] == 13'd0, "R3", "written zero kept", 128'(out_phase_o[1*13 +: 13]), 128'(0));

    // R4: input delay enable
    do_write(mk_addr(T_ID, T_BASE, 1, 3, 8'h01), 32'hFFFF_FFFF);
    check_outs("R4");
    do_read(mk_addr(T_ID, T_BASE, 1, 3, 8'h01), "R7");
    do_write(mk_addr(T_ID, T_BASE, 1, 3, 8'h01), 32'h0000_0055);
    chk(in_dly_o[7*9 +: 9] == 9'd0, "R4", "disabled input delay", 128'(in_dly_o[7*9 +: 9]), 128'(0));

    // R5: strobe input delay enable
    do_write(mk_addr(T_ID, T_BASE, 1, 0, 8'h02), 32'hFFFF_E2AA);
    check_outs("R5");
    do_write(mk_addr(T_ID, T_BASE, 1, 0, 8'h02), 32'h0000_13FF);
    chk(strb_in_dly_o[10 +: 10] == 10'h3FF, "R5", "enabled strobe delay", 128'(strb_in_dly_o[10 +: 10]), 128'h3FF);
    do_read(mk_addr(T_ID, T_BASE, 1, 0, 8'h02), "R5");

    // R6: select bit 15
    do_write(mk_addr(T_ID, T_BASE, 0, 0, 8'h03), 32'h0000_0FFF);
    check_outs("R6");
    do_write(mk_addr(T_ID, T_BASE, 0, 0, 8'h03), 32'h8000_8FFF);
    do_write(mk_addr(T_ID, T_BASE, 0, 0, 8'h04), 32'h0000_803F);
    do_write(mk_addr(T_ID, T_BASE, 0, 0, 8'h05), 32'hFFFF_7F7F);
    check_outs("R6");
    do_read(mk_addr(T_ID, T_BASE, 0, 0, 8'h05), "R7");

    // R9: lane 1 untouched by lane 0 writes
    chk(se_dly_o[6 +: 6] == D_SED, "R9", "lane1 se_dly", 128'(se_dly_o[6 +: 6]), 128'(D_SED));
    chk(se_phase_o[13 +: 13] == D_SEP, "R9", "lane1 se_phase", 128'(se_phase_o[13 +: 13]), 128'(D_SEP));

    // R1: misses
    do_write(mk_addr(4'h6, T_BASE, 0, 0, 8'h00), 32'h1111);
    do_write(mk_addr(T_ID, 3'h2, 0, 0, 8'h00), 32'h1111);
    do_write({T_ID, T_BASE, 3'b010, 8'd0, 5'd0, 8'h00}, 32'h1111);
    do_write(mk_addr(T_ID, T_BASE, 2, 0, 8'h04), 32'h8000_0009);
    do_write(mk_addr(T_ID, T_BASE, 0, 4, 8'h00), 32'h1111);
    chk(out_phase_o[12:0] == D_OPH, "R1", "pin0 phase after misses", 128'(out_phase_o[12:0]), 128'(D_OPH));
    check_outs("R1");
    do_read(mk_addr(4'h6, T_BASE, 0, 1, 8'h00), "R1");
    do_read(mk_addr(T_ID, T_BASE, 0, 4, 8'h00), "R1");

    // R10: unmapped selectors
    do_write(mk_addr(T_ID, T_BASE, 0, 0, 8'h06), 32'hFFFF_FFFF);
    do_write(mk_addr(T_ID, T_BASE, 1, 0, 8'hFF), 32'hFFFF_FFFF);
    check_outs("R10");
    do_read(mk_addr(T_ID, T_BASE, 0, 0, 8'h06), "R10");

    // R8: no valid without a read
    @(negedge clk);
    chk(avs_readdatavalid === 1'b0, "R8", "idle valid", 128'(avs_readdatavalid), 128'(0));

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [3:0] id;
      logic [2:0] b;
      logic [30:0] a;
      id = ($urandom_range(9) == 0) ? 4'h2 : T_ID;
      b  = ($urandom_range(9) == 0) ? 3'h1 : T_BASE;
      a  = mk_addr(id, b, $urandom_range(2), $urandom_range(4), 8'($urandom_range(6)));
      if ($urandom_range(1) == 0) begin
        do_write(a, $urandom());
        check_outs("R9");
      end else begin
        do_read(a, "R7");
      end
    end

    // R3: reset restores defaults
    apply_reset();
    @(negedge clk);
    check_outs("R3");

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule